// File: doc/BRIEF.md
# Interrupt Latency History Ring

This block keeps a short record of the interrupts a processor core has taken, so that debug logic can later see which sources were serviced and how long each one waited. Each source has its own timestamp register. That register captures the free-running cycle count whenever the source's set bit pulses. When the core takes an interrupt, the block writes one entry into a circular history: the source index, the cycle of the take, and the stored timestamp of that source. Once the history is full, each new entry overwrites the oldest one.

Software-facing or debug logic reads the history by offset. Offset 0 is the most recent take, offset 1 the one before it, and so on. Each answer arrives two clock cycles after the request. It carries the stored fields, the latency (take cycle minus raise cycle) and an end marker. The end marker tells the reader to stop walking further back, because the entry has a take cycle of zero. Entries never written since reset read as all-zero, so they are end markers. The depth of the history, the number of sources and the timestamp width are parameters.

Top module: `lat_history_ring`

## Requirements
- R1: In every cycle in which bit s of `set_vec_i` is 1, the raise timestamp of source s is loaded with `cycle_i`. Several bits may load in the same cycle.
- R2: A cycle with `take_i` high writes one entry at the write position. The entry holds `take_src_i`, the value of `cycle_i` as its take cycle, and the raise timestamp that source held before that clock edge. A set pulse for the same source in the same cycle affects only later takes.
- R3: The write position starts at 0 and advances by one per take. After position DEPTH-1 it returns to 0, so take number DEPTH+n overwrites the entry of take n.
- R4: Reset (synchronous, active high) does four things: it clears every history entry, sets the write position to 0, zeroes all raise timestamps and drops `rd_valid_o`. After reset, every offset reads source 0, raise 0, take 0 and latency 0, with the end marker set.
- R5: A read request at offset k returns the entry at write position minus k minus 1, modulo DEPTH. Offset 0 is therefore the newest take.
- R6: `rd_end_o` is 1 exactly when the returned take cycle is 0. This includes a genuine take recorded while `cycle_i` was 0.
- R7: `rd_lat_o` equals the returned take cycle minus the returned raise cycle, modulo 2^TS_W, so a counter wrap between raise and take still gives the true distance.
- R8: When a take and a read request fall in the same cycle, the read returns the history as it stood before that take. This covers both the offset mapping and the entry contents.
- R9: `rd_valid_o` is high for one cycle, exactly two clock cycles after each cycle with `rd_en_i` high. The read fields are meaningful while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_i | input | TS_W | Current cycle count |
| set_vec_i | input | NUM_SRC | One pulse bit per source, raise event |
| take_i | input | 1 | An interrupt is taken this cycle |
| take_src_i | input | IDX_W | Index of the taken source |
| rd_en_i | input | 1 | Read request |
| rd_ofs_i | input | PTR_W | Offset back from the newest entry |
| rd_valid_o | output | 1 | Read result valid |
| rd_src_o | output | IDX_W | Source index of the entry |
| rd_raised_o | output | TS_W | Raise cycle of the entry |
| rd_taken_o | output | TS_W | Take cycle of the entry |
| rd_lat_o | output | TS_W | Take cycle minus raise cycle |
| rd_end_o | output | 1 | Entry has a zero take cycle, stop walking |

## Verification
The hardest situations to reach from the ports are collisions in a single clock edge. One is a take whose own source is raised again in the same cycle. Another is a read issued in the same cycle as a take, where both the offset mapping and the memory word change at that edge. The stimulus drives these deliberately at chosen cycle values. The bench model captures the expected read result before applying the take, and applies the stamp updates after the take. A long arithmetic sweep of takes then wraps the write position several times, and every offset is read back after each group of takes. A mid-run reset and a take at cycle zero exercise the end marker without relying on empty entries.

// File: rtl/lat_hist_pkg.sv
package lat_hist_pkg;
  localparam int unsigned DEF_SRCS  = 16;
  localparam int unsigned DEF_DEPTH = 8;
  localparam int unsigned DEF_TS_W  = 32;

  // index width for a count of n items, at least one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lat_stamp_bank.sv
module lat_stamp_bank #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned TS_W    = 32,
  parameter int unsigned IDX_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [TS_W-1:0]           cycle_i,
  input  logic [NUM_SRC-1:0]        set_vec_i,
  input  logic [IDX_W-1:0]          sel_i,
  output logic [TS_W-1:0]           sel_stamp_o,
  output logic [NUM_SRC*TS_W-1:0]   stamps_o
);
  logic [TS_W-1:0] stamp_q [NUM_SRC];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)               stamp_q[s] <= '0;
      else if (set_vec_i[s]) stamp_q[s] <= cycle_i;
    end
    assign stamps_o[s*TS_W +: TS_W] = stamp_q[s];
  end

  // selected stamp seen by a take, value before this edge's updates
  always_comb begin
    sel_stamp_o = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (sel_i == IDX_W'(s)) sel_stamp_o = stamp_q[s];
    end
  end
endmodule

// File: rtl/lat_hist_mem.sv
module lat_hist_mem #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = 3,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_src_i,
  input  logic [TS_W-1:0]  wr_raised_i,
  input  logic [TS_W-1:0]  wr_taken_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  input  logic             rd_en_i,
  input  logic [PTR_W-1:0] rd_addr_i,
  output logic [IDX_W-1:0] rd_src_o,
  output logic [TS_W-1:0]  rd_raised_o,
  output logic [TS_W-1:0]  rd_taken_o,
  output logic             rd_vld_o
);
  localparam int unsigned WORD_W = IDX_W + 2*TS_W;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  logic [WORD_W-1:0] ram [DEPTH];
  logic [WORD_W-1:0] rd_word_q;
  logic [DEPTH-1:0]  filled_q;
  logic [PTR_W-1:0]  wp_q;

  // storage without reset so it maps onto block RAM, read-before-write
  always_ff @(posedge clk) begin
    if (wr_en_i) ram[wp_q] <= {wr_src_i, wr_raised_i, wr_taken_i};
    if (rd_en_i) rd_word_q <= ram[rd_addr_i];
  end

  // occupancy flags and pointer live in flops and carry the reset
  always_ff @(posedge clk) begin
    if (rst) begin
      filled_q <= '0;
      wp_q     <= '0;
      rd_vld_o <= 1'b0;
    end else begin
      if (rd_en_i) rd_vld_o <= filled_q[rd_addr_i];
      if (wr_en_i) begin
        filled_q[wp_q] <= 1'b1;
        wp_q           <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      end
    end
  end

  assign wr_ptr_o    = wp_q;
  assign rd_src_o    = rd_word_q[WORD_W-1 -: IDX_W];
  assign rd_raised_o = rd_word_q[2*TS_W-1 -: TS_W];
  assign rd_taken_o  = rd_word_q[TS_W-1:0];
endmodule

// File: rtl/lat_rd_path.sv
module lat_rd_path #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = 3,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en_i,
  input  logic [PTR_W-1:0] rd_ofs_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  output logic [PTR_W-1:0] rd_addr_o,
  input  logic [IDX_W-1:0] m_src_i,
  input  logic [TS_W-1:0]  m_raised_i,
  input  logic [TS_W-1:0]  m_taken_i,
  input  logic             m_vld_i,
  output logic             rd_valid_o,
  output logic [IDX_W-1:0] rd_src_o,
  output logic [TS_W-1:0]  rd_raised_o,
  output logic [TS_W-1:0]  rd_taken_o,
  output logic [TS_W-1:0]  rd_lat_o,
  output logic             rd_end_o
);
  localparam int unsigned SUM_W = PTR_W + 2;

  logic [SUM_W-1:0] sum_w;
  logic             oob_w;
  logic             en_d1, oob_d1;
  logic [IDX_W-1:0] src_w;
  logic [TS_W-1:0]  raised_w, taken_w;

  // newest-first mapping: (write position - offset - 1) mod DEPTH
  always_comb begin
    oob_w = (32'(rd_ofs_i) >= DEPTH);
    sum_w = SUM_W'(wr_ptr_i) + SUM_W'(DEPTH - 1) - SUM_W'(rd_ofs_i);
    if (oob_w)                        rd_addr_o = '0;
    else if (sum_w >= SUM_W'(DEPTH))  rd_addr_o = PTR_W'(sum_w - SUM_W'(DEPTH));
    else                              rd_addr_o = PTR_W'(sum_w);
  end

  always_comb begin
    if (m_vld_i && !oob_d1) begin
      src_w    = m_src_i;
      raised_w = m_raised_i;
      taken_w  = m_taken_i;
    end else begin
      src_w    = '0;
      raised_w = '0;
      taken_w  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d1      <= 1'b0;
      oob_d1     <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_src_o   <= '0;
      rd_raised_o <= '0;
      rd_taken_o <= '0;
      rd_lat_o   <= '0;
      rd_end_o   <= 1'b0;
    end else begin
      en_d1      <= rd_en_i;
      oob_d1     <= oob_w;
      rd_valid_o <= en_d1;
      if (en_d1) begin
        rd_src_o    <= src_w;
        rd_raised_o <= raised_w;
        rd_taken_o  <= taken_w;
        rd_lat_o    <= taken_w - raised_w;
        rd_end_o    <= (taken_w == '0);
      end
    end
  end
endmodule

// File: rtl/lat_history_ring.sv
module lat_history_ring
  import lat_hist_pkg::*;
#(
  parameter int unsigned NUM_SRC = DEF_SRCS,
  parameter int unsigned DEPTH   = DEF_DEPTH,
  parameter int unsigned TS_W    = DEF_TS_W,
  localparam int unsigned IDX_W  = idx_w(NUM_SRC),
  localparam int unsigned PTR_W  = idx_w(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TS_W-1:0]    cycle_i,
  input  logic [NUM_SRC-1:0] set_vec_i,
  input  logic               take_i,
  input  logic [IDX_W-1:0]   take_src_i,
  input  logic               rd_en_i,
  input  logic [PTR_W-1:0]   rd_ofs_i,
  output logic               rd_valid_o,
  output logic [IDX_W-1:0]   rd_src_o,
  output logic [TS_W-1:0]    rd_raised_o,
  output logic [TS_W-1:0]    rd_taken_o,
  output logic [TS_W-1:0]    rd_lat_o,
  output logic               rd_end_o
);
  logic [TS_W-1:0]         take_stamp;
  logic [NUM_SRC*TS_W-1:0] stamps_flat;
  logic [PTR_W-1:0]        wr_ptr, rd_addr;
  logic [IDX_W-1:0]        m_src;
  logic [TS_W-1:0]         m_raised, m_taken;
  logic                    m_vld;

  lat_stamp_bank #(.NUM_SRC(NUM_SRC), .TS_W(TS_W), .IDX_W(IDX_W)) u_stamps (
    .clk(clk), .rst(rst), .cycle_i(cycle_i), .set_vec_i(set_vec_i),
    .sel_i(take_src_i), .sel_stamp_o(take_stamp), .stamps_o(stamps_flat)
  );

  lat_hist_mem #(.DEPTH(DEPTH), .PTR_W(PTR_W), .IDX_W(IDX_W), .TS_W(TS_W)) u_mem (
    .clk(clk), .rst(rst),
    .wr_en_i(take_i), .wr_src_i(take_src_i), .wr_raised_i(take_stamp),
    .wr_taken_i(cycle_i), .wr_ptr_o(wr_ptr),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr),
    .rd_src_o(m_src), .rd_raised_o(m_raised), .rd_taken_o(m_taken), .rd_vld_o(m_vld)
  );

  lat_rd_path #(.DEPTH(DEPTH), .PTR_W(PTR_W), .IDX_W(IDX_W), .TS_W(TS_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .rd_ofs_i(rd_ofs_i),
    .wr_ptr_i(wr_ptr), .rd_addr_o(rd_addr),
    .m_src_i(m_src), .m_raised_i(m_raised), .m_taken_i(m_taken), .m_vld_i(m_vld),
    .rd_valid_o(rd_valid_o), .rd_src_o(rd_src_o), .rd_raised_o(rd_raised_o),
    .rd_taken_o(rd_taken_o), .rd_lat_o(rd_lat_o), .rd_end_o(rd_end_o)
  );
endmodule

// File: rtl/lat_hist_chk.sv
module lat_hist_chk #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned TS_W    = 32,
  parameter int unsigned PTR_W   = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic [TS_W-1:0]         cycle_i,
  input logic [NUM_SRC-1:0]      set_vec_i,
  input logic                    take_i,
  input logic                    rd_en_i,
  input logic                    rd_valid_o,
  input logic [TS_W-1:0]         rd_taken_o,
  input logic                    rd_end_o,
  input logic [PTR_W-1:0]        wr_ptr,
  input logic [NUM_SRC*TS_W-1:0] stamps
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    // R1: a set pulse loads the source's stamp at the next edge
    p_stamp_load_r1: assert property (@(posedge clk) disable iff (rst)
      set_vec_i[s] |=> stamps[s*TS_W +: TS_W] == $past(cycle_i));
  end

  // R3: pointer steps by one per take and wraps after DEPTH-1
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
    take_i |=> wr_ptr == (($past(wr_ptr) == PTR_W'(DEPTH-1)) ? '0 : $past(wr_ptr) + 1'b1));

  // R3: pointer holds when nothing is taken
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> $stable(wr_ptr));

  // R4: pointer is zero right after reset
  p_ptr_reset_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> wr_ptr == '0);

  // R9: every request produces a valid result two cycles later
  p_valid_after_req_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> ##1 rd_valid_o);

  // R9: no result without a request two cycles earlier
  p_valid_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(rd_en_i, 2));

  // R6: a non-end result never carries a zero take cycle
  p_end_marker_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !rd_end_o) |-> rd_taken_o != '0);
endmodule

bind lat_history_ring lat_hist_chk #(
  .NUM_SRC(NUM_SRC), .DEPTH(DEPTH), .TS_W(TS_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst(rst), .cycle_i(cycle_i), .set_vec_i(set_vec_i),
  .take_i(take_i), .rd_en_i(rd_en_i), .rd_valid_o(rd_valid_o),
  .rd_taken_o(rd_taken_o), .rd_end_o(rd_end_o),
  .wr_ptr(wr_ptr), .stamps(stamps_flat)
);

// File: tb/test_lat_history_ring.sv
module test_lat_history_ring;
  localparam int NS = 16;
  localparam int D  = 8;
  localparam int TW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [TW-1:0] cycle_i;
  logic [NS-1:0] set_vec_i;
  logic          take_i;
  logic [3:0]    take_src_i;
  logic          rd_en_i;
  logic [2:0]    rd_ofs_i;
  logic          rd_valid_o;
  logic [3:0]    rd_src_o;
  logic [TW-1:0] rd_raised_o, rd_taken_o, rd_lat_o;
  logic          rd_end_o;

  always #10 clk = ~clk;

  lat_history_ring i_lat_history_ring (
    .clk(clk), .rst(rst), .cycle_i(cycle_i), .set_vec_i(set_vec_i),
    .take_i(take_i), .take_src_i(take_src_i), .rd_en_i(rd_en_i), .rd_ofs_i(rd_ofs_i),
    .rd_valid_o(rd_valid_o), .rd_src_o(rd_src_o), .rd_raised_o(rd_raised_o),
    .rd_taken_o(rd_taken_o), .rd_lat_o(rd_lat_o), .rd_end_o(rd_end_o)
  );

  int total = 0;
  int bad   = 0;

  logic [TW-1:0] m_stamp [NS];
  logic [3:0]    m_src   [D];
  logic [TW-1:0] m_raised[D];
  logic [TW-1:0] m_taken [D];
  logic          m_vld   [D];
  int            m_ptr;

  logic [3:0]    e_src;
  logic [TW-1:0] e_raised, e_taken;

  task automatic chk(input string req, input string what, input logic [TW-1:0] got,
                     input logic [TW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic model_clear();
    m_ptr = 0;
    for (int i = 0; i < D; i++) begin
      m_src[i] = '0; m_raised[i] = '0; m_taken[i] = '0; m_vld[i] = 1'b0;
    end
    for (int s = 0; s < NS; s++) m_stamp[s] = '0;
  endtask

  // one clock: drive at negedge, update model, wait for the rising edge
  task automatic step(input logic [TW-1:0] cv, input logic [NS-1:0] sv, input logic tk,
                      input logic [3:0] ts, input logic rd, input logic [2:0] ro);
    @(negedge clk);
    cycle_i = cv; set_vec_i = sv; take_i = tk; take_src_i = ts;
    rd_en_i = rd; rd_ofs_i = ro;
    if (rd) begin
      int idx;
      idx = (m_ptr + D - 1 - int'(ro)) % D;
      e_src    = m_vld[idx] ? m_src[idx]    : '0;
      e_raised = m_vld[idx] ? m_raised[idx] : '0;
      e_taken  = m_vld[idx] ? m_taken[idx]  : '0;
    end
    if (tk) begin
      m_src[m_ptr]    = ts;
      m_raised[m_ptr] = m_stamp[ts];
      m_taken[m_ptr]  = cv;
      m_vld[m_ptr]    = 1'b1;
      m_ptr           = (m_ptr + 1) % D;
    end
    for (int s = 0; s < NS; s++) if (sv[s]) m_stamp[s] = cv;
    @(posedge clk);
  endtask

  task automatic idle();
    step('0, '0, 1'b0, 4'd0, 1'b0, 3'd0);
  endtask

  task automatic check_result(input string req);
    @(negedge clk);
    chk(req, "valid R9", {31'd0, rd_valid_o}, 32'd1);
    chk(req, "src R5", {28'd0, rd_src_o}, {28'd0, e_src});
    chk(req, "raised R2", rd_raised_o, e_raised);
    chk(req, "taken R2", rd_taken_o, e_taken);
    chk(req, "latency R7", rd_lat_o, e_taken - e_raised);
    chk(req, "end R6", {31'd0, rd_end_o}, {31'd0, (e_taken == '0)});
  endtask

  task automatic read_chk(input logic [2:0] k, input string req);
    step('0, '0, 1'b0, 4'd0, 1'b1, k);
    idle();
    check_result(req);
  endtask

  task automatic read_all(input string req);
    for (int k = 0; k < D; k++) read_chk(3'(k), req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cycle_i = '0; set_vec_i = '0; take_i = 1'b0; take_src_i = '0;
    rd_en_i = 1'b0; rd_ofs_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R4: reset state, nothing valid and every offset is an end marker
    chk("R4", "valid after reset", {31'd0, rd_valid_o}, 32'd0);
    read_all("R4 R6 reset contents");

    // R1 R2 R5 R7: two sources raised together, taken in turn
    step(32'd40, 16'h0208, 1'b0, 4'd0, 1'b0, 3'd0);
    step(32'd55, '0, 1'b1, 4'd3, 1'b0, 3'd0);
    step(32'd60, '0, 1'b1, 4'd9, 1'b0, 3'd0);
    idle();
    read_chk(3'd0, "R1 R5 newest");
    read_chk(3'd1, "R1 R5 older");
    read_chk(3'd2, "R6 first empty");

    // R2: set and take of the same source in one cycle uses the old stamp
    step(32'd70, 16'h0020, 1'b0, 4'd0, 1'b0, 3'd0);
    step(32'd90, 16'h0020, 1'b1, 4'd5, 1'b0, 3'd0);
    step(32'd100, '0, 1'b1, 4'd5, 1'b0, 3'd0);
    idle();
    read_chk(3'd1, "R2 same-cycle set");
    read_chk(3'd0, "R2 R1 reloaded stamp");

    // R8: read and take together, read sees pre-write history
    step(32'd120, '0, 1'b1, 4'd9, 1'b1, 3'd0);
    idle();
    check_result("R8 pre-write read");
    read_chk(3'd0, "R8 write landed");

    // R6: a real take at cycle zero reads as an end marker
    step(32'd0, '0, 1'b1, 4'd1, 1'b0, 3'd0);
    idle();
    read_chk(3'd0, "R6 zero take cycle");
    read_chk(3'd1, "R6 entry behind marker");

    // R7: counter wrap between raise and take
    step(32'hFFFF_FFF0, 16'h0004, 1'b0, 4'd0, 1'b0, 3'd0);
    step(32'd5, '0, 1'b1, 4'd2, 1'b0, 3'd0);
    idle();
    read_chk(3'd0, "R7 wrapped latency");

    // R3 R5: arithmetic sweep wrapping the ring several times
    for (int i = 0; i < 24; i++) begin
      step(32'(200 + i*7), NS'(1) << ((i*5) % NS), 1'b0, 4'd0, 1'b0, 3'd0);
      step(32'(400 + i*11), '0, 1'b1, 4'((i*3) % NS), 1'b0, 3'd0);
      if (i % 6 == 5) begin
        idle();
        read_all("R3 R5 sweep");
      end
    end

    // R4: reset in mid-run clears entries, pointer and stamps
    do_reset();
    read_all("R4 mid-run reset");
    step(32'd300, '0, 1'b1, 4'd4, 1'b0, 3'd0);
    idle();
    read_chk(3'd0, "R4 stamp cleared");
    read_chk(3'd1, "R4 R3 pointer restarted");

    idle();
    @(negedge clk);
    chk("R9", "valid idle", {31'd0, rd_valid_o}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule